// File: doc/BRIEF.md
# Doubleword-Aligned Wrap Buffer Loader

This block fills a bank of staging buffers from a memory word stream. Each buffer holds one 128-byte line, which is sixteen 64-bit doublewords. A load command carries a line address, a primary buffer index, a secondary buffer index and a 4-bit doubleword offset. The block issues the line address to memory in the same cycle it accepts the command. It then steers the sixteen returning doublewords so that the line starts at the chosen offset inside the primary buffer. Words that fall past the last slot of the primary buffer continue at slot 0 of the secondary buffer.

Chaining loads builds realigned components. A load of line A uses primary P, secondary S and offset k. A second load of line A+1 then uses primary S, a new secondary and the same offset k. After both loads, buffer S holds sixteen consecutive doublewords that start at word 16-k of line A. A receive buffer can therefore begin at any doubleword.

Commands may be accepted while earlier lines are still arriving, up to a parameterised number of loads in flight. The returning words are consumed in command order. Each buffer has a full flag and a free command. A combinational read port exposes any buffer slot.

Top module: `wrap_buffer_loader`

## Requirements
- R1: After reset, all full flags are 0, `cmd_ready` is 1, and `mem_req_valid` and `load_done` are 0.
- R2: In the cycle a command is accepted (`cmd_valid` and `cmd_ready`), `mem_req_valid` is 1 and `mem_req_addr` equals `cmd_addr`. With PEND loads in flight, `cmd_ready` is 0 and no request is issued.
- R3: Word i of a load (counting from 0 in arrival order) is written to slot offset+i of the primary buffer when offset+i is below 16.
- R4: When offset+i is 16 or more, word i is written to slot offset+i-16 of the secondary buffer.
- R5: With offset 0, the whole line lands in the primary buffer and the secondary buffer is left unchanged.
- R6: Primary slots below the offset keep their previous contents.
- R7: Loads in flight complete in command order. A command accepted while an earlier line is still arriving takes the words that follow that line's sixteenth word.
- R8: A buffer's full flag is 1 once all 16 of its slots have been written since it was last freed. A free command with no write to that buffer in the same cycle makes the flag 0 on the next cycle.
- R9: A load of line A+1 whose primary buffer is the previous load's secondary buffer, and which uses the same offset, leaves that buffer full and holding line A words 16-k..15 followed by line A+1 words 0..15-k.
- R10: `load_done` is 1 for one cycle, in the cycle after the sixteenth word of a load is taken. The buffer contents are readable in that cycle.
- R11: A write to a buffer in the same cycle as its free still counts towards the full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load command present |
| cmd_ready | output | 1 | Room for another load in flight |
| cmd_pri | input | BUF_W | Primary buffer index |
| cmd_sec | input | BUF_W | Secondary buffer index |
| cmd_addr | input | ADDR_W | Line address |
| cmd_off | input | 4 | Starting doubleword slot in the primary buffer |
| mem_req_valid | output | 1 | Memory line request |
| mem_req_addr | output | ADDR_W | Requested line address |
| mem_rd_valid | input | 1 | Memory word present |
| mem_rd_data | input | 64 | Memory doubleword |
| free_valid | input | 1 | Free command |
| free_buf | input | BUF_W | Buffer to free |
| rd_buf | input | BUF_W | Read port buffer index |
| rd_pos | input | 4 | Read port slot |
| rd_data | output | 64 | Read port data |
| buf_full | output | NUM_BUFS | Per-buffer full flags |
| load_done | output | 1 | Pulse after a load's last word |

## Verification
The bench uses offsets 0, 5 and 15. Offset 0 checks that the secondary buffer is left alone. Offset 15 pushes almost the whole line through the wrap. A middle offset with a chained second load checks that a component comes out aligned. Bursts of back-to-back commands against a memory model with 14-cycle latency overlap the word streams and fill the in-flight queue. These bursts show whether words are attached to the right command and whether the block stalls when the queue is full. Random offsets and buffer pairs are mixed with frees, including a free in the same cycle as a write, and the results are compared with a shadow copy of every buffer slot and full flag.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
    localparam int LINE_WORDS = 16;
    localparam int SLOT_W     = $clog2(LINE_WORDS);
    localparam int WORD_W     = 64;

    typedef logic [WORD_W-1:0] dword_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  to_sec;
        slot_t pos;
    } route_t;

    // Where word idx of a load with starting slot off lands.
    function automatic route_t route_word(slot_t off, slot_t idx);
        logic [SLOT_W:0] sum;
        route_t r;
        sum      = {1'b0, off} + {1'b0, idx};
        r.to_sec = sum[SLOT_W];
        r.pos    = sum[SLOT_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/wbl_ctx_fifo.sv
module wbl_ctx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wbl_sequencer.sv
module wbl_sequencer
    import wbl_pkg::*;
#(
    parameter int BUF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_valid,
    input  logic [BUF_W-1:0] head_pri,
    input  logic [BUF_W-1:0] head_sec,
    input  slot_t            head_off,
    output logic             wr_en,
    output logic [BUF_W-1:0] wr_buf,
    output slot_t            wr_pos,
    output logic             pop,
    output logic             done
);
    slot_t  widx;
    route_t rt;

    assign rt     = route_word(head_off, widx);
    assign wr_en  = word_valid;
    assign wr_buf = rt.to_sec ? head_sec : head_pri;
    assign wr_pos = rt.pos;
    assign pop    = word_valid && (widx == slot_t'(LINE_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            widx <= '0;
            done <= 1'b0;
        end else begin
            done <= pop;
            if (word_valid) widx <= widx + 1'b1;
        end
    end
endmodule

// File: rtl/wbl_buf_array.sv
module wbl_buf_array
    import wbl_pkg::*;
#(
    parameter int NUM_BUFS = 8,
    parameter int BUF_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [BUF_W-1:0]    wr_buf,
    input  slot_t               wr_pos,
    input  dword_t              wr_data,
    input  logic                free_en,
    input  logic [BUF_W-1:0]    free_buf,
    input  logic [BUF_W-1:0]    rd_buf,
    input  slot_t               rd_pos,
    output dword_t              rd_data,
    output logic [NUM_BUFS-1:0] full
);
    dword_t                mem [NUM_BUFS][LINE_WORDS];
    logic [LINE_WORDS-1:0] mask [NUM_BUFS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_buf][wr_pos] <= wr_data;
    end

    assign rd_data = mem[rd_buf][rd_pos];

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_mask
        logic                  hit_w, hit_f;
        logic [LINE_WORDS-1:0] set_bit;
        assign hit_w   = wr_en && (wr_buf == BUF_W'(b));
        assign hit_f   = free_en && (free_buf == BUF_W'(b));
        assign set_bit = hit_w ? (LINE_WORDS'(1) << wr_pos) : '0;
        always_ff @(posedge clk) begin
            if (rst) mask[b] <= '0;
            else     mask[b] <= (hit_f ? '0 : mask[b]) | set_bit;
        end
        assign full[b] = &mask[b];
    end
endmodule

// File: rtl/wrap_buffer_loader.sv
module wrap_buffer_loader
    import wbl_pkg::*;
#(
    parameter int NUM_BUFS = 8,
    parameter int ADDR_W   = 32,
    parameter int PEND     = 4,
    parameter int BUF_W    = $clog2(NUM_BUFS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [BUF_W-1:0]    cmd_pri,
    input  logic [BUF_W-1:0]    cmd_sec,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [3:0]          cmd_off,
    output logic                mem_req_valid,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rd_valid,
    input  logic [63:0]         mem_rd_data,
    input  logic                free_valid,
    input  logic [BUF_W-1:0]    free_buf,
    input  logic [BUF_W-1:0]    rd_buf,
    input  logic [3:0]          rd_pos,
    output logic [63:0]         rd_data,
    output logic [NUM_BUFS-1:0] buf_full,
    output logic                load_done
);
    localparam int CTX_W = 2 * BUF_W + SLOT_W;

    logic             q_full, q_empty, pop, accept;
    logic [CTX_W-1:0] head;
    logic             wr_en;
    logic [BUF_W-1:0] wr_buf;
    slot_t            wr_pos;

    assign cmd_ready     = !q_full;
    assign accept        = cmd_valid && cmd_ready;
    assign mem_req_valid = accept;
    assign mem_req_addr  = cmd_addr;

    wbl_ctx_fifo #(.W(CTX_W), .DEPTH(PEND)) ctx_q (
        .clk(clk), .rst(rst),
        .push(accept), .push_data({cmd_pri, cmd_sec, cmd_off}),
        .pop(pop), .head(head), .full(q_full), .empty(q_empty)
    );

    wbl_sequencer #(.BUF_W(BUF_W)) seq_i (
        .clk(clk), .rst(rst),
        .word_valid(mem_rd_valid && !q_empty),
        .head_pri(head[CTX_W-1 -: BUF_W]),
        .head_sec(head[SLOT_W +: BUF_W]),
        .head_off(head[SLOT_W-1:0]),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_pos(wr_pos),
        .pop(pop), .done(load_done)
    );

    wbl_buf_array #(.NUM_BUFS(NUM_BUFS), .BUF_W(BUF_W)) bufs_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_pos(wr_pos), .wr_data(mem_rd_data),
        .free_en(free_valid), .free_buf(free_buf),
        .rd_buf(rd_buf), .rd_pos(rd_pos), .rd_data(rd_data),
        .full(buf_full)
    );
endmodule

// File: rtl/wbl_checker.sv
module wbl_checker #(
    parameter int NUM_BUFS = 8,
    parameter int ADDR_W   = 32,
    parameter int PEND     = 4,
    parameter int BUF_W    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [ADDR_W-1:0]   cmd_addr,
    input logic                mem_req_valid,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic                mem_rd_valid,
    input logic                free_valid,
    input logic [BUF_W-1:0]    free_buf,
    input logic [NUM_BUFS-1:0] buf_full,
    input logic                load_done
);
    int         inflight;
    logic [3:0] wcnt;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            inflight <= 0;
            wcnt     <= '0;
        end else begin
            inflight <= inflight + (mem_req_valid ? 1 : 0)
                        - ((mem_rd_valid && wcnt == 4'd15) ? 1 : 0);
            if (mem_rd_valid) wcnt <= wcnt + 1'b1;
        end
    end

    // R1: state right after reset
    always @(posedge clk) begin
        if (rst_q && !rst)
            p_reset_state_r1: assert (buf_full == '0 && !load_done && cmd_ready);
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        inflight <= PEND);

    p_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (inflight == PEND) |-> !mem_req_valid);

    p_req_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (cmd_valid && mem_req_addr == cmd_addr));

    p_done_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && wcnt == 4'd15) |=> load_done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        load_done |-> $past(mem_rd_valid));

    p_free_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (free_valid && !mem_rd_valid) |=> !buf_full[$past(free_buf)]);

    p_full_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_valid && !free_valid) |=> $stable(buf_full));
endmodule

bind wrap_buffer_loader wbl_checker #(
    .NUM_BUFS(NUM_BUFS), .ADDR_W(ADDR_W), .PEND(PEND), .BUF_W(BUF_W)
) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rd_valid(mem_rd_valid),
    .free_valid(free_valid), .free_buf(free_buf),
    .buf_full(buf_full), .load_done(load_done)
);

// File: tb/wrap_buffer_loader_tb_top.sv
module wrap_buffer_loader_tb_top;
    localparam int NB = 8;
    localparam int AW = 32;
    localparam int PD = 4;
    localparam int BW = 3;
    localparam int QN = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0, cmd_ready;
    logic [BW-1:0] cmd_pri = '0, cmd_sec = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [3:0]    cmd_off = '0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rd_valid = 1'b0;
    logic [63:0]   mem_rd_data = '0;
    logic          free_valid;
    logic [BW-1:0] free_buf;
    logic [BW-1:0] rd_buf = '0;
    logic [3:0]    rd_pos = '0;
    logic [63:0]   rd_data;
    logic [NB-1:0] buf_full;
    logic          load_done;

    logic          free_main = 1'b0, free_hook = 1'b0;
    logic [BW-1:0] free_main_b = '0, free_hook_b = '0;
    assign free_valid = free_main | free_hook;
    assign free_buf   = free_hook ? free_hook_b : free_main_b;

    always #2 clk = ~clk;   // 250 MHz

    wrap_buffer_loader #(.NUM_BUFS(NB), .ADDR_W(AW), .PEND(PD)) dut_i (.*);

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model request queue
    logic [AW-1:0] q_addr  [QN];
    int            q_start [QN];
    int qh = 0, qt = 0, last_end = 0, widx = 0, hook_req = -1;

    // shadow state
    logic [63:0] sh  [NB][16];
    bit          kn  [NB][16];
    bit          msk [NB][16];

    function automatic logic [63:0] mword(logic [AW-1:0] a, int i);
        return {a, 28'h5A5A000, 4'(i)};
    endfunction

    function automatic bit sh_full(int b);
        for (int p = 0; p < 16; p++) if (!msk[b][p]) return 0;
        return 1;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory word driver: first word 14 cycles after request, one per cycle
    initial begin
        forever begin
            @(negedge clk);
            free_hook = 1'b0;
            if (qh != qt && cyc >= q_start[qh]) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mword(q_addr[qh], widx);
                if (widx == 0 && qh == hook_req) free_hook = 1'b1;
                if (widx == 15) begin widx = 0; qh++; end
                else widx++;
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic do_load(logic [AW-1:0] a, int pri, int sec, int off, output int n);
        @(negedge clk);
        cmd_addr = a; cmd_pri = BW'(pri); cmd_sec = BW'(sec); cmd_off = 4'(off);
        cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        chk(mem_req_valid && mem_req_addr == a, "R2 request", {31'b0, mem_req_valid, mem_req_addr}, {32'h1, a});
        n = cyc;
        q_addr[qt]  = a;
        q_start[qt] = (n + 14 > last_end) ? n + 14 : last_end;
        last_end    = q_start[qt] + 16;
        qt++;
        for (int i = 0; i < 16; i++) begin
            int r = off + i;
            int b = (r < 16) ? pri : sec;
            sh[b][r % 16] = mword(a, i); kn[b][r % 16] = 1; msk[b][r % 16] = 1;
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (qh != qt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_free(int b);
        @(negedge clk);
        free_main = 1'b1; free_main_b = BW'(b);
        @(posedge clk); #1;
        free_main = 1'b0;
        for (int p = 0; p < 16; p++) msk[b][p] = 0;
        @(negedge clk);
        chk(buf_full[b] == 1'b0, "R8 free clears", 64'(buf_full[b]), 64'd0);
    endtask

    task automatic check_buf(int b, string tag);
        @(negedge clk);
        for (int p = 0; p < 16; p++) begin
            if (kn[b][p]) begin
                rd_buf = BW'(b); rd_pos = 4'(p);
                #1;
                chk(rd_data == sh[b][p], tag, rd_data, sh[b][p]);
            end
        end
        chk(buf_full[b] == sh_full(b), "R8 full flag", 64'(buf_full[b]), 64'(sh_full(b)));
    endtask

    task automatic check_all(string tag);
        for (int b = 0; b < NB; b++) check_buf(b, tag);
    endtask

    initial begin
        int n;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < 16; p++) begin kn[b][p] = 0; msk[b][p] = 0; sh[b][p] = '0; end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(buf_full == '0, "R1 full flags", 64'(buf_full), 64'd0);
        chk(cmd_ready == 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
        chk(mem_req_valid == 1'b0 && load_done == 1'b0, "R1 idle outputs",
            {62'b0, mem_req_valid, load_done}, 64'd0);

        // isolated load, offset 0, timing of done pulse
        do_load(32'h1000, 0, 1, 0, n);
        while (cyc < n + 29) @(negedge clk);
        chk(load_done == 1'b0, "R10 done not early", 64'(load_done), 64'd0);
        @(negedge clk);
        chk(load_done == 1'b1, "R10 done pulse", 64'(load_done), 64'd1);
        check_buf(0, "R10 data visible");
        @(negedge clk);
        chk(load_done == 1'b0, "R10 one cycle", 64'(load_done), 64'd0);

        // fill the remaining buffers with offset-0 loads
        for (int b = 1; b < NB; b++) do_load(32'h1000 + b, b, (b + 1) % NB, 0, n);
        wait_idle();
        check_all("R3 offset 0 fill");

        // offset 0 with a free in the cycle of the first word
        do_free(6);
        hook_req = qt;
        free_hook_b = 3'd6;
        do_load(32'h2000, 6, 7, 0, n);
        wait_idle();
        hook_req = -1;
        chk(buf_full[6] == 1'b1, "R11 write with free", 64'(buf_full[6]), 64'd1);
        check_buf(7, "R5 secondary untouched");
        check_buf(6, "R3 primary line");

        // chained component at offset 5, second issued while first arrives
        do_free(3);
        do_free(4);
        do_load(32'h3000, 2, 3, 5, n);
        do_load(32'h3001, 3, 4, 5, n);
        wait_idle();
        chk(buf_full[3] == 1'b1, "R9 component full", 64'(buf_full[3]), 64'd1);
        chk(buf_full[4] == 1'b0, "R8 partial not full", 64'(buf_full[4]), 64'd0);
        check_buf(3, "R9 component data");
        check_buf(2, "R6 below offset kept");
        check_buf(4, "R4 wrapped words");

        // queue full stall
        for (int k = 0; k < PD; k++) do_load(32'h4000 + k, k, k + 4, k * 3, n);
        @(negedge clk); #1;
        chk(cmd_ready == 1'b0, "R2 stall when full", 64'(cmd_ready), 64'd0);
        do_load(32'h4100, 5, 6, 9, n);
        wait_idle();
        check_all("R7 in-order overlap");

        // offset 15 corner
        do_load(32'h5000, 0, 1, 15, n);
        wait_idle();
        check_buf(0, "R3 offset 15 primary");
        check_buf(1, "R4 offset 15 secondary");

        // constrained random
        void'($urandom(32'd17));
        for (int it = 0; it < 60; it++) begin
            int p = $urandom_range(NB - 1);
            int s = (p + 1 + $urandom_range(NB - 2)) % NB;
            do_load($urandom, p, s, $urandom_range(15), n);
            if (it % 10 == 9) begin
                wait_idle();
                check_all("R4 random mix");
                do_free($urandom_range(NB - 1));
            end
        end
        wait_idle();
        check_all("R3 random final");
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule